// File: doc/BRIEF.md
# Shared Byte Mailbox with Stall Handshake and Host Interrupt Flag

This block lets two bus masters, a coprocessor and a host, pass bytes to each other through a single shared byte register. Either side may write the register or read it. One occupancy flag records whether the register holds an unread byte. An access that cannot proceed is stalled through that side's wait output and is not rejected. A write is blocked while the register is occupied, and a read is blocked while it is vacant. The master keeps its request asserted until the wait output drops, and the access completes in that same cycle.

Beside the data path sits an interrupt-request flag. The coprocessor raises it to tell the host that it wants service. The host clears it with a write to its control address. The host can also poll the flag, together with the occupancy flag, through a status read that never stalls. Both sides run on one common clock. Every request, grant and wait signal within a cycle is combinational, and the state changes at the clock edge.

Top module: `byte_mailbox`

## Requirements
- R1: After reset the register is vacant and the interrupt flag is clear. With no requests, both wait outputs are low and both read buses are zero.
- R2: A data write (sel, wr, addr 0) from either side to a vacant register completes in the cycle it is presented, with wait low. From the next cycle the register is occupied and holds the written byte.
- R3: A data read (sel, rd, addr 0) from either side of an occupied register completes in the cycle it is presented, with wait low. In that cycle the stored byte is on that side's read bus, and from the next cycle the register is vacant. Outside a completed data read or a status read, the read bus is zero.
- R4: A data write to an occupied register asserts that side's wait and leaves the stored byte unchanged. The write completes, with wait low, in the first cycle the register is vacant at the start of the cycle.
- R5: A data read of a vacant register asserts that side's wait. The read completes, with wait low, in the first cycle the register is occupied at the start of the cycle.
- R6: Bytes pass in both directions, and a side may read back the byte it wrote itself.
- R7: At most one data access completes per cycle. When both sides present data writes to a vacant register, the coprocessor's write completes and the host waits. When both present data reads of an occupied register, the coprocessor's read completes and the host waits.
- R8: A coprocessor write to address 1 sets the interrupt flag, and the flag drives the interrupt output from the next cycle. A host write to address 1 clears it. If both happen in the same cycle, the flag is set.
- R9: A host read of address 1 never waits. It returns the interrupt flag on bit 0, the occupancy flag on bit 1 and zero on the other bits, and it changes neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_sel | input | 1 | Coprocessor select |
| cp_rd | input | 1 | Coprocessor read strobe |
| cp_wr | input | 1 | Coprocessor write strobe |
| cp_addr | input | 1 | Coprocessor address: 0 data, 1 interrupt raise |
| cp_wdata | input | DATA_W | Coprocessor write data |
| cp_rdata | output | DATA_W | Coprocessor read data |
| cp_wait | output | 1 | Coprocessor stall |
| hs_sel | input | 1 | Host select |
| hs_rd | input | 1 | Host read strobe |
| hs_wr | input | 1 | Host write strobe |
| hs_addr | input | 1 | Host address: 0 data, 1 status/interrupt clear |
| hs_wdata | input | DATA_W | Host write data |
| hs_rdata | output | DATA_W | Host read data |
| hs_wait | output | 1 | Host stall |
| host_irq | output | 1 | Interrupt request to the host |

## Verification
The bench targets these corner cases:
- A read and a blocked write presented in the same cycle. A design that let the write through early would overwrite an unread byte. One that held the write a cycle too long would show a wait output that stays high after the register has emptied.
- Simultaneous writes or simultaneous reads from both sides. These expose a wrong priority, or a double completion that loses a byte or hands one byte to both masters.
- A set and a clear of the interrupt flag in the same cycle, which would drop a request if the clear won.
- Status polls between accesses, which reveal a poll that stalls or disturbs a flag.

Long stretches of pseudo-random traffic are compared cycle by cycle against a behavioural model.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int STAT_IRQ_BIT  = 0;
  localparam int STAT_FULL_BIT = 1;

  typedef struct packed {
    logic cp_wr;
    logic hs_wr;
    logic cp_rd;
    logic hs_rd;
  } grant_t;

  // Fixed-priority pick between two requesters for one slot: {second, first}.
  function automatic logic [1:0] pick2(input logic first_req, input logic second_req,
                                       input logic slot_ok);
    logic [1:0] r;
    r[0] = slot_ok & first_req;
    r[1] = slot_ok & second_req & ~first_req;
    return r;
  endfunction
endpackage

// File: rtl/mbox_arbiter.sv
module mbox_arbiter
  import mbox_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   full,
  input  logic   cp_wr_req,
  input  logic   hs_wr_req,
  input  logic   cp_rd_req,
  input  logic   hs_rd_req,
  output grant_t grant
);
  logic [1:0] wr_pick, rd_pick;

  always_comb begin
    wr_pick = pick2(cp_wr_req, hs_wr_req, ~full);
    rd_pick = pick2(cp_rd_req, hs_rd_req, full);
    grant.cp_wr = wr_pick[0];
    grant.hs_wr = wr_pick[1];
    grant.cp_rd = rd_pick[0];
    grant.hs_rd = rd_pick[1];
  end

  assert_one_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant.cp_wr, grant.hs_wr, grant.cp_rd, grant.hs_rd}));

  assert_cp_write_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_wr_req && hs_wr_req && !full) |-> (grant.cp_wr && !grant.hs_wr));
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_from_hs,
  input  logic [DATA_W-1:0] cp_wdata,
  input  logic [DATA_W-1:0] hs_wdata,
  input  logic              rd_en,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr_en) begin
      full <= 1'b1;
      data <= wr_from_hs ? hs_wdata : cp_wdata;
    end else if (rd_en) begin
      full <= 1'b0;
    end
  end

  assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);

  assert_no_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> full);

  assert_byte_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !wr_en) |=> $stable(data));

  assert_fill_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> full);

  assert_drain_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !full);
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic drop,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq <= 1'b0;
    else if (raise) irq <= 1'b1;
    else if (drop)  irq <= 1'b0;
  end

  assert_raise_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> irq);

  assert_drop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !raise) |=> !irq);
endmodule

// File: rtl/byte_mailbox.sv
module byte_mailbox
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cp_sel,
  input  logic              cp_rd,
  input  logic              cp_wr,
  input  logic              cp_addr,
  input  logic [DATA_W-1:0] cp_wdata,
  output logic [DATA_W-1:0] cp_rdata,
  output logic              cp_wait,
  input  logic              hs_sel,
  input  logic              hs_rd,
  input  logic              hs_wr,
  input  logic              hs_addr,
  input  logic [DATA_W-1:0] hs_wdata,
  output logic [DATA_W-1:0] hs_rdata,
  output logic              hs_wait,
  output logic              host_irq
);
  // Named internal events for the checks.
  logic cp_wr_req, hs_wr_req, cp_rd_req, hs_rd_req;
  logic irq_raise, irq_drop, stat_rd;
  logic full;
  logic [DATA_W-1:0] held;
  grant_t grant;
  logic [DATA_W-1:0] status_word;

  assign cp_wr_req = cp_sel & cp_wr & ~cp_addr;
  assign cp_rd_req = cp_sel & cp_rd & ~cp_wr & ~cp_addr;
  assign hs_wr_req = hs_sel & hs_wr & ~hs_addr;
  assign hs_rd_req = hs_sel & hs_rd & ~hs_wr & ~hs_addr;
  assign irq_raise = cp_sel & cp_wr & cp_addr;
  assign irq_drop  = hs_sel & hs_wr & hs_addr;
  assign stat_rd   = hs_sel & hs_rd & ~hs_wr & hs_addr;

  mbox_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .full(full),
    .cp_wr_req(cp_wr_req), .hs_wr_req(hs_wr_req),
    .cp_rd_req(cp_rd_req), .hs_rd_req(hs_rd_req),
    .grant(grant)
  );

  mbox_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(grant.cp_wr | grant.hs_wr), .wr_from_hs(grant.hs_wr),
    .cp_wdata(cp_wdata), .hs_wdata(hs_wdata),
    .rd_en(grant.cp_rd | grant.hs_rd),
    .full(full), .data(held)
  );

  mbox_irq u_irq (
    .clk(clk), .rst_n(rst_n), .raise(irq_raise), .drop(irq_drop), .irq(host_irq)
  );

  always_comb begin
    status_word = '0;
    status_word[STAT_IRQ_BIT]  = host_irq;
    status_word[STAT_FULL_BIT] = full;
  end

  assign cp_wait  = (cp_wr_req & ~grant.cp_wr) | (cp_rd_req & ~grant.cp_rd);
  assign hs_wait  = (hs_wr_req & ~grant.hs_wr) | (hs_rd_req & ~grant.hs_rd);
  assign cp_rdata = grant.cp_rd ? held : '0;
  assign hs_rdata = stat_rd ? status_word : (grant.hs_rd ? held : '0);

  assert_stall_write_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_wr_req && full) |-> cp_wait);

  assert_stall_read_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rd_req && !full) |-> hs_wait);

  assert_status_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> !hs_wait);

  assert_status_keeps_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cp_sel) |=> $stable(full));
endmodule

// File: tb/byte_mailbox_bench.sv
module byte_mailbox_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cp_sel = 0, cp_rd = 0, cp_wr = 0, cp_addr = 0;
  logic hs_sel = 0, hs_rd = 0, hs_wr = 0, hs_addr = 0;
  logic [7:0] cp_wdata = 0, hs_wdata = 0;
  logic [7:0] cp_rdata, hs_rdata;
  logic cp_wait, hs_wait, host_irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // behavioural reference state
  bit m_full = 0;
  bit m_irq = 0;
  int m_byte = 0;

  always #5 clk = ~clk;

  byte_mailbox u_byte_mailbox (
    .clk(clk), .rst_n(rst_n),
    .cp_sel(cp_sel), .cp_rd(cp_rd), .cp_wr(cp_wr), .cp_addr(cp_addr),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_wait(cp_wait),
    .hs_sel(hs_sel), .hs_rd(hs_rd), .hs_wr(hs_wr), .hs_addr(hs_addr),
    .hs_wdata(hs_wdata), .hs_rdata(hs_rdata), .hs_wait(hs_wait),
    .host_irq(host_irq)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive after the falling edge, compare, then advance the model.
  task automatic cyc(input string tag,
                     input bit cs, input bit crd, input bit cwr, input bit ca, input int cd,
                     input bit hs, input bit hrd, input bit hwr, input bit ha, input int hd);
    bit c_wq, c_rq, h_wq, h_rq, done_cw, done_hw, done_cr, done_hr;
    int exp_crd, exp_hrd;
    @(negedge clk);
    cp_sel = cs; cp_rd = crd; cp_wr = cwr; cp_addr = ca; cp_wdata = cd[7:0];
    hs_sel = hs; hs_rd = hrd; hs_wr = hwr; hs_addr = ha; hs_wdata = hd[7:0];
    #1;
    c_wq = cs && cwr && !ca;
    c_rq = cs && crd && !cwr && !ca;
    h_wq = hs && hwr && !ha;
    h_rq = hs && hrd && !hwr && !ha;
    done_cw = 0; done_hw = 0; done_cr = 0; done_hr = 0;
    if (!m_full) begin
      if (c_wq) done_cw = 1;
      else if (h_wq) done_hw = 1;
    end else begin
      if (c_rq) done_cr = 1;
      else if (h_rq) done_hr = 1;
    end
    exp_crd = done_cr ? m_byte : 0;
    if (hs && hrd && !hwr && ha) exp_hrd = (m_full ? 2 : 0) + (m_irq ? 1 : 0);
    else exp_hrd = done_hr ? m_byte : 0;
    chk(tag, "cp_wait", cp_wait, (c_wq && !done_cw) || (c_rq && !done_cr));
    chk(tag, "hs_wait", hs_wait, (h_wq && !done_hw) || (h_rq && !done_hr));
    chk(tag, "cp_rdata", cp_rdata, exp_crd);
    chk(tag, "hs_rdata", hs_rdata, exp_hrd);
    chk(tag, "host_irq", host_irq, m_irq);
    if (done_cw) begin m_full = 1; m_byte = cd & 255; end
    if (done_hw) begin m_full = 1; m_byte = hd & 255; end
    if (done_cr || done_hr) m_full = 0;
    if (cs && cwr && ca) m_irq = 1;
    else if (hs && hwr && ha) m_irq = 0;
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0,0,0,0,0, 0,0,0,0,0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, idle and status poll
    idle("R1");
    cyc("R1", 0,0,0,0,0, 1,1,0,1,0);
    // R2: coprocessor write to vacant register
    cyc("R2", 1,0,1,0,'hA5, 0,0,0,0,0);
    cyc("R9", 0,0,0,0,0, 1,1,0,1,0);
    // R4: write while occupied stalls, then meets a host read in the same cycle
    cyc("R4", 1,0,1,0,'h3C, 0,0,0,0,0);
    cyc("R4", 1,0,1,0,'h3C, 0,0,0,0,0);
    cyc("R4", 1,0,1,0,'h3C, 1,1,0,0,0);
    cyc("R4", 1,0,1,0,'h3C, 0,0,0,0,0);
    // R3: host reads the second byte
    cyc("R3", 0,0,0,0,0, 1,1,0,0,0);
    // R5: host read of vacant register stalls until the coprocessor fills it
    cyc("R5", 0,0,0,0,0, 1,1,0,0,0);
    cyc("R5", 0,0,0,0,0, 1,1,0,0,0);
    cyc("R5", 1,0,1,0,'h77, 1,1,0,0,0);
    cyc("R5", 0,0,0,0,0, 1,1,0,0,0);
    // R7: simultaneous writes, coprocessor first
    cyc("R7", 1,0,1,0,'h11, 1,0,1,0,'h22);
    // R6: coprocessor reads its own byte while host write waits
    cyc("R6", 1,1,0,0,0, 1,0,1,0,'h22);
    cyc("R6", 0,0,0,0,0, 1,0,1,0,'h22);
    // R7: simultaneous reads, coprocessor first
    cyc("R7", 1,1,0,0,0, 1,1,0,0,0);
    cyc("R7", 0,0,0,0,0, 1,1,0,0,0);
    // R6: host to coprocessor and host reading its own byte
    cyc("R6", 0,0,0,0,0, 1,0,1,0,'h5A);
    cyc("R6", 0,0,0,0,0, 1,1,0,0,0);
    // R8: interrupt raise, poll, clear, and collision
    cyc("R8", 1,0,1,1,0, 0,0,0,0,0);
    cyc("R9", 0,0,0,0,0, 1,1,0,1,0);
    cyc("R8", 0,0,0,0,0, 1,0,1,1,0);
    idle("R8");
    cyc("R8", 1,0,1,1,0, 1,0,1,1,0);
    idle("R8");
    cyc("R8", 0,0,0,0,0, 1,0,1,1,0);
    idle("R8");
    // R9: status poll while a byte is held must not disturb occupancy
    cyc("R9", 1,0,1,0,'hC3, 0,0,0,0,0);
    cyc("R9", 0,0,0,0,0, 1,1,0,1,0);
    cyc("R9", 0,0,0,0,0, 1,1,0,0,0);
    // R6: mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      int a = $urandom;
      int b = $urandom;
      cyc("R6", a[0], a[1], a[2] & ~a[1], (a[7:4] == 0), (a >> 8) & 255,
                b[0], b[1], b[2] & ~b[1], (b[7:4] == 0), (b >> 8) & 255);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule